// File: doc/BRIEF.md
# Two-Wire Command Slave for a Four-Channel Wiper Controller

This block is a two-wire serial bus slave that sits in front of the register bank of a four-channel wiper controller. It oversamples the bus clock and data lines on the system clock and recognises the bus start and end conditions. It accepts one fixed command frame: a seven-bit address, an instruction byte and a data byte. When a complete frame has been acknowledged, it presents the opcode, channel and data to the register bank as one single-cycle strobe.

A read frame makes the slave return one register byte. The channel of the last accepted instruction selects the register, and the register bank supplies the byte combinationally on `rdData`. The slave drives only an output enable for the data line; the open-drain pad is outside the block. While the nonvolatile store reports busy, new instructions are refused.

Top module: `wcs_top`

## Requirements
- R1: An SDA fall while SCL is high starts address reception. An SDA rise while SCL is high ends the frame. After that end, bits clocked without a new start are not acknowledged.
- R2: The slave pulls SDA low (`sdaOe`=1) in the ninth clock when the first seven received bits equal 0,1,0,1,1,`strapAddr[1]`,`strapAddr[0]`. Bits are received MSB first, and the eighth bit is the direction (0 write, 1 read). This holds whatever the state of `storeBusy`.
- R3: For any other address, the slave never drives SDA and issues no strobe until the next start.
- R4: In a write frame the instruction byte and the data byte are both acknowledged. The data acknowledge is accompanied by exactly one `cmdValid` pulse, with `cmdOpcode` = instruction bits 7..4, `cmdChannel` = instruction bits 1..0 and `cmdData` = the data byte.
- R5: With `DATA_W`=6, `cmdData` carries data bits 5..0 and bits 7..6 are discarded.
- R6: If `storeBusy` is high at the end of the instruction byte, that byte is not acknowledged and no strobe follows. `storeBusy` has no effect at any other point of the frame.
- R7: A start arriving inside a frame abandons the frame without a strobe and restarts address reception.
- R8: After a read address is acknowledged, the slave shifts out the byte on `rdData` MSB first. `rdSel` equals the channel of the last accepted instruction. SDA changes only while SCL is low, and the slave releases SDA after the eighth bit.
- R9: `cmdValid` lasts one clock, and `cmdData` changes only together with it.
- R10: After reset `sdaOe` and `cmdValid` are 0.
- R11: Bytes after the data byte of a write frame are not acknowledged and produce no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapAddr | input | 2 | Low two address bits from strap pins |
| storeBusy | input | 1 | Nonvolatile store busy; refuses new instructions |
| rdData | input | 8 | Register byte selected by rdSel |
| sdaOe | output | 1 | 1 pulls SDA low |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdOpcode | output | 4 | Opcode of the strobed command |
| cmdChannel | output | 2 | Channel of the strobed command |
| cmdData | output | DATA_W | Data of the strobed command |
| rdSel | output | 2 | Channel of the last accepted instruction |

## Verification
The interesting collision is between the busy input and the acceptance of the instruction byte. Both are decided on the same synchronised SCL fall that ends the eighth instruction bit. The bench holds `storeBusy` high across that fall in one table row and expects a NACK and no strobe. In a directed case it raises `storeBusy` only after the instruction has been acknowledged and expects the data byte to be acknowledged and strobed normally. A repeated start placed in the middle of the data byte is judged the same way, by the strobe count and the fields of the next complete frame.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  // events seen on the synchronised bus
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic byteFull;
    logic txLast;
  } busEv_t;

  // strobes from control into datapath
  typedef struct packed {
    logic shiftIn;
    logic clrCnt;
    logic captureInstr;
    logic captureData;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_ACK, ST_READ, ST_WAIT
  } state_t;

  localparam logic [4:0] ADDR_PREFIX = 5'b01011;
endpackage

// File: rtl/wcs_dp.sv
module wcs_dp
  import wcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] instrByte,
  output logic [BYTE_W-1:0] dataByte,
  output logic              txNext
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  // synchroniser stages plus one history stage per line
  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_W-1:0]    txShift;
  logic sclNow, sclOld, sdaNow, sdaOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  always_comb begin
    ev.sclRise  = sclNow & ~sclOld;
    ev.sclFall  = ~sclNow & sclOld;
    ev.start    = sclNow & sclOld & sdaOld & ~sdaNow;
    ev.stop     = sclNow & sclOld & ~sdaOld & sdaNow;
    ev.byteFull = (bitCnt == CNT_W'(BYTE_W));
    ev.txLast   = (bitCnt == CNT_W'(BYTE_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxByte    <= '0;
      txShift   <= '0;
      instrByte <= '0;
      dataByte  <= '0;
    end else begin
      if (ctl.clrCnt)                      bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx) bitCnt <= bitCnt + 1'b1;
      if (ctl.shiftIn)      rxByte    <= {rxByte[BYTE_W-2:0], sdaNow};
      if (ctl.loadTx)       txShift   <= rdData;
      else if (ctl.shiftTx) txShift   <= {txShift[BYTE_W-2:0], 1'b0};
      if (ctl.captureInstr) instrByte <= rxByte;
      if (ctl.captureData)  dataByte  <= rxByte;
    end
  end

  assign txNext = txShift[BYTE_W-2];
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
  import wcs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [1:0]        strapAddr,
  input  logic              storeBusy,
  input  logic              rdMsb,
  input  logic              txNext,
  output dpCtl_t            ctl,
  output logic              sdaOe,
  output logic              cmdValid
);
  state_t st, stNx, afterAck, afterAckNx;
  logic   oeNx, validNx;
  logic   addrHit;

  assign addrHit = (rxByte[BYTE_W-1:1] == {ADDR_PREFIX, strapAddr});

  always_comb begin
    ctl        = '0;
    stNx       = st;
    afterAckNx = afterAck;
    oeNx       = sdaOe;
    validNx    = 1'b0;
    if (ev.start) begin
      stNx       = ST_ADDR;
      ctl.clrCnt = 1'b1;
      oeNx       = 1'b0;
    end else if (ev.stop) begin
      stNx = ST_IDLE;
      oeNx = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (ev.sclRise && !ev.byteFull) begin
            ctl.shiftIn = 1'b1;
          end else if (ev.sclFall && ev.byteFull) begin
            ctl.clrCnt = 1'b1;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                oeNx       = 1'b1;
                stNx       = ST_ACK;
                afterAckNx = rxByte[0] ? ST_READ : ST_INSTR;
              end else begin
                stNx = ST_WAIT;
              end
            end else if (st == ST_INSTR) begin
              if (storeBusy) begin
                stNx = ST_WAIT;
              end else begin
                ctl.captureInstr = 1'b1;
                oeNx             = 1'b1;
                stNx             = ST_ACK;
                afterAckNx       = ST_DATA;
              end
            end else begin
              ctl.captureData = 1'b1;
              validNx         = 1'b1;
              oeNx            = 1'b1;
              stNx            = ST_ACK;
              afterAckNx      = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            stNx = afterAck;
            oeNx = 1'b0;
            if (afterAck == ST_READ) begin
              ctl.loadTx = 1'b1;
              oeNx       = ~rdMsb;
            end
          end
        end
        ST_READ: begin
          if (ev.sclFall) begin
            if (ev.txLast) begin
              oeNx = 1'b0;
              stNx = ST_WAIT;
            end else begin
              ctl.shiftTx = 1'b1;
              oeNx        = ~txNext;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      afterAck <= ST_IDLE;
      sdaOe    <= 1'b0;
      cmdValid <= 1'b0;
    end else begin
      st       <= stNx;
      afterAck <= afterAckNx;
      sdaOe    <= oeNx;
      cmdValid <= validNx;
    end
  end
endmodule

// File: rtl/wcs_top.sv
module wcs_top
  import wcs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapAddr,
  input  logic              storeBusy,
  input  logic [7:0]        rdData,
  output logic              sdaOe,
  output logic              cmdValid,
  output logic [3:0]        cmdOpcode,
  output logic [1:0]        cmdChannel,
  output logic [DATA_W-1:0] cmdData,
  output logic [1:0]        rdSel
);
  localparam int BYTE_W = 8;

  busEv_t            ev;
  dpCtl_t            ctl;
  logic [BYTE_W-1:0] rxByte, instrByte, dataByte;
  logic              txNext;
  logic              unusedBits;

  wcs_dp #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .rdData(rdData), .ev(ev), .rxByte(rxByte), .instrByte(instrByte),
    .dataByte(dataByte), .txNext(txNext)
  );

  wcs_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .strapAddr(strapAddr),
    .storeBusy(storeBusy), .rdMsb(rdData[BYTE_W-1]), .txNext(txNext),
    .ctl(ctl), .sdaOe(sdaOe), .cmdValid(cmdValid)
  );

  assign cmdOpcode  = instrByte[7:4];
  assign cmdChannel = instrByte[1:0];
  assign rdSel      = instrByte[1:0];
  assign cmdData    = dataByte[DATA_W-1:0];
  assign unusedBits = ^{instrByte[3:2], dataByte};
endmodule

// File: rtl/wcs_chk.sv
module wcs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              cmdValid,
  input logic [DATA_W-1:0] cmdData
);
  // R9: strobe is a single cycle
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R4: the strobe coincides with the data-byte acknowledge
  a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> sdaOe);

  // R9: command data moves only with the strobe
  a_r9_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdData) |-> cmdValid);

  // R8: the slave changes SDA only while SCL is low
  a_r8_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind wcs_top wcs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .cmdValid(cmdValid), .cmdData(cmdData)
);

// File: tb/wcs_top_tb.sv
module wcs_top_tb;
  localparam int Q = 10;
  localparam logic [6:0] ADR_MAIN = 7'h2D;  // strap 01
  localparam logic [6:0] ADR_NARR = 7'h2F;  // strap 11
  // {addr7, instr8, data8, busy, expAddrAck, expInstrAck, expDataAck}
  localparam logic [26:0] VEC [6] = '{
    {7'h2D, 8'h31, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1},
    {7'h2D, 8'hF2, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    {7'h2C, 8'h13, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'h6D, 8'h13, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'h2D, 8'h43, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'h2F, 8'h13, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, storeBusy = 1'b0;
  logic sdaOe, sdaOeN, cmdValid, cmdValidN;
  logic [3:0] cmdOpcode, cmdOpcodeN;
  logic [1:0] cmdChannel, cmdChannelN, rdSel, rdSelN;
  logic [7:0] cmdData, rdData, rdDataN;
  logic [5:0] cmdDataN;
  logic sdaBus;
  logic [7:0] regs [4];
  int checks = 0, errors = 0, strobes = 0, strobesN = 0;
  logic [3:0] lastOp;
  logic [1:0] lastCh;
  logic [7:0] lastData;
  logic [5:0] lastDataN;
  bit done = 0;

  always #5 clk = ~clk;

  assign sdaBus  = sdaM & ~sdaOe & ~sdaOeN;
  assign rdData  = regs[rdSel];
  assign rdDataN = regs[rdSelN];

  wcs_top u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(2'b01),
    .storeBusy(storeBusy), .rdData(rdData), .sdaOe(sdaOe), .cmdValid(cmdValid),
    .cmdOpcode(cmdOpcode), .cmdChannel(cmdChannel), .cmdData(cmdData), .rdSel(rdSel)
  );

  wcs_top #(.DATA_W(6)) u_dut_narrow (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(2'b11),
    .storeBusy(storeBusy), .rdData(rdDataN), .sdaOe(sdaOeN), .cmdValid(cmdValidN),
    .cmdOpcode(cmdOpcodeN), .cmdChannel(cmdChannelN), .cmdData(cmdDataN), .rdSel(rdSelN)
  );

  always @(negedge clk) begin
    if (cmdValid) begin
      strobes++; lastOp = cmdOpcode; lastCh = cmdChannel; lastData = cmdData;
    end
    if (cmdValidN) begin
      strobesN++; lastDataN = cmdDataN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; wq(); sclM = 1; wq(); sdaM = 0; wq(); sclM = 0; wq();
  endtask

  task automatic busStop();
    sdaM = 0; wq(); sclM = 1; wq(); sdaM = 1; wq(); wq();
  endtask

  task automatic clockBit(input logic b);
    sdaM = b; wq(); sclM = 1; wq(); wq(); sclM = 0; wq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
    sdaM = 1; wq(); sclM = 1; wq(); ack = ~sdaBus; wq(); sclM = 0; wq();
  endtask

  task automatic readByte(output logic [7:0] b);
    sdaM = 1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); sclM = 1; wq(); b = {b[6:0], sdaBus}; wq(); sclM = 0; wq();
    end
    clockBit(1'b1);  // master NACK
  endtask

  task automatic writeFrame(input logic [7:0] ins, input logic [7:0] dat,
                            output logic aA, output logic aI, output logic aD);
    aA = 0; aI = 0; aD = 0;
    busStart();
    sendByte({ADR_MAIN, 1'b0}, aA);
    if (aA) sendByte(ins, aI);
    if (aI) sendByte(dat, aD);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic aA, aI, aD, ack;
    logic [7:0] rb;
    int s0;
    regs[0] = 8'h11; regs[1] = 8'h5A; regs[2] = 8'hC6; regs[3] = 8'h93;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(sdaOe == 0 && sdaOeN == 0, "R10 sdaOe in reset", int'(sdaOe), 0);
    check(cmdValid == 0, "R10 cmdValid in reset", int'(cmdValid), 0);
    rstN = 1;
    repeat (5) @(negedge clk);
    check(sdaOe == 0 && cmdValid == 0, "R10 quiet after reset", int'(sdaOe), 0);

    // table of frames: R2 R3 R4 R5 R6
    foreach (VEC[k]) begin
      logic [6:0] adr;
      logic [7:0] ins, dat;
      logic bsy, eA, eI, eD, narrow;
      int sm, sn;
      {adr, ins, dat, bsy, eA, eI, eD} = VEC[k];
      narrow = (adr == ADR_NARR);
      sm = strobes; sn = strobesN;
      aA = 0; aI = 0; aD = 0;
      storeBusy = bsy;
      busStart();
      sendByte({adr, 1'b0}, aA);
      if (aA) sendByte(ins, aI);
      if (aI) sendByte(dat, aD);
      busStop();
      storeBusy = 0;
      check(aA == eA, eA ? "R2 address ack" : "R3 address nack", int'(aA), int'(eA));
      if (eA) check(aI == eI, bsy ? "R6 busy instr nack" : "R4 instr ack", int'(aI), int'(eI));
      if (eI) check(aD == eD, "R4 data ack", int'(aD), int'(eD));
      if (narrow) begin
        check(strobesN - sn == 1, "R5 narrow strobe", strobesN - sn, 1);
        check(lastDataN == dat[5:0], "R5 narrow data", int'(lastDataN), int'(dat[5:0]));
        check(strobes == sm, "R3 other slave quiet", strobes - sm, 0);
      end else begin
        check(strobes - sm == int'(eA & eI & eD),
              bsy ? "R6 no strobe" : (eA ? "R4 strobe count" : "R3 no strobe"),
              strobes - sm, int'(eA & eI & eD));
        if (eA & eI & eD)
          check(lastOp == ins[7:4] && lastCh == ins[1:0] && lastData == dat,
                "R4 command fields", {lastOp, lastCh, lastData}, {ins[7:4], ins[1:0], dat});
      end
    end

    // R1: bits clocked after STOP without a START are ignored
    sendByte({ADR_MAIN, 1'b0}, ack);
    check(ack == 0, "R1 no ack without start", int'(ack), 0);
    busStop();

    // R6: busy raised only after the instruction ack has no effect
    s0 = strobes;
    busStart();
    sendByte({ADR_MAIN, 1'b0}, aA);
    sendByte(8'h70, aI);
    storeBusy = 1;
    sendByte(8'h99, aD);
    busStop();
    storeBusy = 0;
    check(aD == 1 && strobes - s0 == 1 && lastData == 8'h99, "R6 late busy ignored",
          strobes - s0, 1);

    // R7: repeated start inside the data byte
    s0 = strobes;
    busStart();
    sendByte({ADR_MAIN, 1'b0}, aA);
    sendByte(8'h23, aI);
    for (int i = 0; i < 4; i++) clockBit(1'b1);
    check(strobes == s0, "R7 no strobe on partial", strobes - s0, 0);
    busStart();
    sendByte({ADR_MAIN, 1'b0}, aA);
    check(aA == 1, "R7 address after restart", int'(aA), 1);
    sendByte(8'h61, aI);
    sendByte(8'h3C, aD);
    busStop();
    check(strobes - s0 == 1, "R7 one strobe", strobes - s0, 1);
    check(lastOp == 4'h6 && lastCh == 2'd1 && lastData == 8'h3C, "R7 fields",
          {lastOp, lastCh, lastData}, {4'h6, 2'd1, 8'h3C});

    // R11: extra byte after data is refused
    s0 = strobes;
    busStart();
    sendByte({ADR_MAIN, 1'b0}, aA);
    sendByte(8'h82, aI);
    sendByte(8'h44, aD);
    sendByte(8'h11, ack);
    busStop();
    check(ack == 0, "R11 extra byte nack", int'(ack), 0);
    check(strobes - s0 == 1 && lastData == 8'h44, "R11 single strobe", strobes - s0, 1);

    // R8: read back the register picked by the last channel
    writeFrame(8'h52, 8'h10, aA, aI, aD);
    check(rdSel == 2'd2, "R8 rdSel", int'(rdSel), 2);
    busStart();
    sendByte({ADR_MAIN, 1'b1}, aA);
    check(aA == 1, "R8 read address ack", int'(aA), 1);
    readByte(rb);
    busStop();
    check(rb == regs[2], "R8 read byte ch2", int'(rb), int'(regs[2]));
    check(sdaOe == 0, "R8 released after byte", int'(sdaOe), 0);
    writeFrame(8'h41, 8'h00, aA, aI, aD);
    busStart();
    sendByte({ADR_MAIN, 1'b1}, aA);
    readByte(rb);
    busStop();
    check(rb == regs[1], "R8 read byte ch1", int'(rb), int'(regs[1]));

    finishRun();
  end
endmodule